// File: doc/BRIEF.md
# Board Control and Display Register Block

This block is a set of memory-mapped control registers for a development board, served over a simple 32-bit read/write bus. It holds an 8-bit LED bar and an 8-character display buffer. Software fills the buffer in one of two ways. It can store a single character at a time. It can also write a whole 32-bit word, which the block turns into eight uppercase hexadecimal digits. The block also holds a general-purpose output byte and a software reset trigger. A set of bit-bang I2C control registers drives the SCL and SDA lines of an external serial EEPROM and reads back the SDA level that the EEPROM returns. The LED bits and the eight character codes leave the block as plain output ports. Rendering them on a display happens outside the block.

A single bus controller state machine serves each access. The states are ST_IDLE, ST_WR and ST_RD. In ST_IDLE the block raises `bus_ready`, and a request that arrives is accepted. Acceptance takes transition IDLE_TO_WR when `bus_we` is high and IDLE_TO_RD when it is low. The decoded target, the character index and the write data are latched at that point. ST_WR lasts exactly one cycle. It raises `bus_ack` and commits the write at the clock edge that ends the state, then takes transition WR_TO_IDLE. ST_RD also lasts exactly one cycle. It raises `bus_ack` and presents `bus_rdata` together with the bad-access flag, then takes transition RD_TO_IDLE. When no request is present, the controller stays in ST_IDLE through transition IDLE_HOLD.

The register map uses only the low 20 bits of the bus address as the offset:

| Offset | Register | Access |
|---|---|---|
| 0x000 | switch register | read |
| 0x408 | LED bar | read/write |
| 0x410 | whole-word display | write |
| 0x418 + 8·i, i = 0 to 7 | display character i | write |
| 0x500 | software reset trigger | write |
| 0xA00 | general-purpose output | read/write |
| 0xB00 | I2C input | read |
| 0xB08 | I2C output enable | read/write |
| 0xB10 | I2C output | read/write |
| 0xB18 | I2C select | read/write |

Top module: `board_ctl`

## Requirements
- R1: Only bits 19:0 of `bus_addr` select a register. An access whose upper 12 address bits are arbitrary reaches the same register as one whose upper bits are zero.
- R2: A write to offset 0x408 stores bits 7:0 of the data on `led_bar`. A read of 0x408 returns that byte zero-extended.
- R3: A write to offset 0x410 fills the display with eight uppercase hexadecimal ASCII digits of the written word. Bits 31:28 go to character 0 and bits 3:0 go to character 7. Character i sits at `disp_chars[8i+7:8i]`. The digits 0 to 9 are codes 0x30 to 0x39, and A to F are codes 0x41 to 0x46.
- R4: A write to offset 0x418 + 8·i, for i from 0 to 7, stores bits 7:0 of the data as character i. No other character changes.
- R5: After reset every character is 0x20. `led_bar`, `gp_out`, `i2c_oe`, `i2c_sel`, `i2c_scl_o` and `i2c_sda_o` are all 0. `sys_reset_req` and `bus_ack` are low, and `bus_ready` is high.
- R6: A read of offset 0x000, the switch register, returns 0, meaning all switches are closed.
- R7: In the I2C output register at 0xB10, bit 1 drives `i2c_scl_o` and bit 0 drives `i2c_sda_o`. The output-enable register at 0xB08 keeps bits 1:0, and the select register at 0xB18 keeps bit 0. All three read back the bits they keep.
- R8: A read of the I2C input register at 0xB00 returns the level of `i2c_sda_i` in bit 0. Bit 1 holds the stored SCL output bit, and the bits above it are 0.
- R9: A write to offset 0xA00 stores bits 7:0 on `gp_out`. A read of 0xA00 returns that byte.
- R10: A write to offset 0x500 raises `sys_reset_req` for exactly the ST_WR cycle, but only when the written value is 0x00000042. Any other value leaves it low.
- R11: A read of an offset that maps to no register returns 0 and raises `bus_bad` for its single ST_RD cycle. A write to such an offset changes no register. Reads of the write-only offsets return 0 without raising `bus_bad`.
- R12: `bus_ready` is high only in ST_IDLE. Each accepted request raises `bus_ack` for exactly one cycle, in the cycle right after it is accepted. A completed write shows on the outputs from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address (low 20 bits decoded) |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request can be accepted this cycle |
| bus_ack | output | 1 | Access completes this cycle |
| bus_rdata | output | 32 | Read data, valid with a read acknowledge |
| bus_bad | output | 1 | Read hit an undecoded offset |
| led_bar | output | 8 | LED bar bits |
| disp_chars | output | 64 | Eight display character codes, character i in bits 8i+7:8i |
| gp_out | output | 8 | General-purpose outputs |
| sys_reset_req | output | 1 | One-cycle system reset request |
| i2c_scl_o | output | 1 | SCL level toward the EEPROM |
| i2c_sda_o | output | 1 | SDA level toward the EEPROM |
| i2c_oe | output | 2 | I2C output-enable bits |
| i2c_sel | output | 1 | I2C select bit |
| i2c_sda_i | input | 1 | SDA level returned by the EEPROM |

## Verification
The bench builds the block with its default parameters: a 32-bit address with a 20-bit decoded offset, 32-bit data, eight characters and 8-bit LED and output registers. With a 20-bit offset inside a 32-bit address, the bench can set the upper twelve bits to nonzero values and confirm that the access still reaches the same register. With eight characters on a stride of 8, every legal character slot can be written. The unaligned offsets that fall between slots can also be reached, and they must not decode. Because the data width is four times the character count, every nibble of a whole-word write has a display position of its own. This lets the bench confirm that the nibble order is correct.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_SWITCH,
        REG_LED,
        REG_WORD,
        REG_CHAR,
        REG_SWRST,
        REG_GPOUT,
        REG_I2C_IN,
        REG_I2C_OE,
        REG_I2C_OUT,
        REG_I2C_SEL
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR,
        ST_RD
    } bus_state_e;

    localparam int unsigned OFFS_SWITCH  = 32'h000;
    localparam int unsigned OFFS_LED     = 32'h408;
    localparam int unsigned OFFS_WORD    = 32'h410;
    localparam int unsigned OFFS_CHAR0   = 32'h418;
    localparam int unsigned CHAR_STRIDE  = 8;
    localparam int unsigned OFFS_SWRST   = 32'h500;
    localparam int unsigned OFFS_GPOUT   = 32'hA00;
    localparam int unsigned OFFS_I2C_IN  = 32'hB00;
    localparam int unsigned OFFS_I2C_OE  = 32'hB08;
    localparam int unsigned OFFS_I2C_OUT = 32'hB10;
    localparam int unsigned OFFS_I2C_SEL = 32'hB18;

    localparam logic [31:0] SWRST_KEY   = 32'h0000_0042;
    localparam logic [7:0]  BLANK_CHAR  = 8'h20;

    // Nibble to uppercase hexadecimal ASCII code.
    function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
        if (n < 4'd10) begin
            return 8'h30 + {4'h0, n};
        end
        return 8'h41 + {4'h0, n} - 8'd10;
    endfunction

endpackage

// File: rtl/board_ctl_decode.sv
module board_ctl_decode
    import board_ctl_pkg::*;
#(
    parameter int OFFS_W    = 20,
    parameter int NUM_CHARS = 8,
    localparam int IDX_W    = (NUM_CHARS > 1) ? $clog2(NUM_CHARS) : 1
) (
    input  logic [OFFS_W-1:0] offs,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  char_idx
);

    logic [NUM_CHARS-1:0] char_hit;

    // One comparator per character slot; only aligned slot offsets hit.
    for (genvar gi = 0; gi < NUM_CHARS; gi++) begin : g_slot
        assign char_hit[gi] = (offs == OFFS_W'(OFFS_CHAR0 + gi * CHAR_STRIDE));
    end

    always_comb begin
        char_idx = '0;
        for (int i = 0; i < NUM_CHARS; i++) begin
            if (char_hit[i]) begin
                char_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        sel = REG_NONE;
        if (|char_hit) begin
            sel = REG_CHAR;
        end else begin
            unique case (offs)
                OFFS_W'(OFFS_SWITCH):  sel = REG_SWITCH;
                OFFS_W'(OFFS_LED):     sel = REG_LED;
                OFFS_W'(OFFS_WORD):    sel = REG_WORD;
                OFFS_W'(OFFS_SWRST):   sel = REG_SWRST;
                OFFS_W'(OFFS_GPOUT):   sel = REG_GPOUT;
                OFFS_W'(OFFS_I2C_IN):  sel = REG_I2C_IN;
                OFFS_W'(OFFS_I2C_OE):  sel = REG_I2C_OE;
                OFFS_W'(OFFS_I2C_OUT): sel = REG_I2C_OUT;
                OFFS_W'(OFFS_I2C_SEL): sel = REG_I2C_SEL;
                default:               sel = REG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/board_ctl_display.sv
module board_ctl_display
    import board_ctl_pkg::*;
#(
    parameter int NUM_CHARS = 8,
    localparam int IDX_W    = (NUM_CHARS > 1) ? $clog2(NUM_CHARS) : 1,
    localparam int WORD_W   = 4 * NUM_CHARS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   word_we,
    input  logic [WORD_W-1:0]      word_val,
    input  logic                   char_we,
    input  logic [IDX_W-1:0]       char_idx,
    input  logic [7:0]             char_val,
    output logic [8*NUM_CHARS-1:0] chars
);

    for (genvar gi = 0; gi < NUM_CHARS; gi++) begin : g_char
        // Character 0 takes the most significant nibble.
        localparam int NIB_LSB = 4 * (NUM_CHARS - 1 - gi);
        logic [7:0] cell_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= BLANK_CHAR;
            end else if (word_we) begin
                cell_q <= nib_to_ascii(word_val[NIB_LSB +: 4]);
            end else if (char_we && (char_idx == IDX_W'(gi))) begin
                cell_q <= char_val;
            end
        end

        assign chars[8*gi +: 8] = cell_q;
    end

endmodule

// File: rtl/board_ctl_i2c.sv
module board_ctl_i2c #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_we,
    input  logic              oe_we,
    input  logic              sel_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sda_in,
    output logic              scl_o,
    output logic              sda_o,
    output logic [1:0]        oe,
    output logic              sel,
    output logic [DATA_W-1:0] in_word,
    output logic [DATA_W-1:0] out_word,
    output logic [DATA_W-1:0] oe_word,
    output logic [DATA_W-1:0] sel_word
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_o <= 1'b0;
            sda_o <= 1'b0;
            oe    <= 2'b00;
            sel   <= 1'b0;
        end else begin
            if (out_we) begin
                scl_o <= wdata[1];
                sda_o <= wdata[0];
            end
            if (oe_we) begin
                oe <= wdata[1:0];
            end
            if (sel_we) begin
                sel <= wdata[0];
            end
        end
    end

    // Input view: stored output bits above bit 0, live SDA level in bit 0.
    assign in_word  = {{(DATA_W-2){1'b0}}, scl_o, sda_in};
    assign out_word = {{(DATA_W-2){1'b0}}, scl_o, sda_o};
    assign oe_word  = {{(DATA_W-2){1'b0}}, oe};
    assign sel_word = {{(DATA_W-1){1'b0}}, sel};

endmodule

// File: rtl/board_ctl.sv
module board_ctl
    import board_ctl_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int OFFS_W    = 20,
    parameter int NUM_CHARS = 8,
    parameter int LED_W     = 8,
    parameter int GP_W      = 8,
    localparam int IDX_W    = (NUM_CHARS > 1) ? $clog2(NUM_CHARS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_req,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic                   bus_ready,
    output logic                   bus_ack,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   bus_bad,
    output logic [LED_W-1:0]       led_bar,
    output logic [8*NUM_CHARS-1:0] disp_chars,
    output logic [GP_W-1:0]        gp_out,
    output logic                   sys_reset_req,
    output logic                   i2c_scl_o,
    output logic                   i2c_sda_o,
    output logic [1:0]             i2c_oe,
    output logic                   i2c_sel,
    input  logic                   i2c_sda_i
);

    bus_state_e        state_q, state_d;
    reg_sel_e          dec_sel, sel_q;
    logic [IDX_W-1:0]  dec_idx, idx_q;
    logic [DATA_W-1:0] wdata_q;
    logic              accept;

    logic wr_led, wr_word, wr_char, wr_gp, wr_i2c_out, wr_i2c_oe, wr_i2c_sel;
    logic [LED_W-1:0] led_q;
    logic [GP_W-1:0]  gp_q;
    logic [DATA_W-1:0] i2c_in_w, i2c_out_w, i2c_oe_w, i2c_sel_w;

    board_ctl_decode #(
        .OFFS_W    (OFFS_W),
        .NUM_CHARS (NUM_CHARS)
    ) u_decode (
        .offs     (bus_addr[OFFS_W-1:0]),
        .sel      (dec_sel),
        .char_idx (dec_idx)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: IDLE_HOLD, IDLE_TO_WR, IDLE_TO_RD, WR_TO_IDLE, RD_TO_IDLE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_req) begin
                    state_d = bus_we ? ST_WR : ST_RD;
                end
            end
            ST_WR:   state_d = ST_IDLE;
            ST_RD:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign accept = (state_q == ST_IDLE) && bus_req;

    // Latch the decoded access at acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= REG_NONE;
            idx_q   <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            sel_q   <= dec_sel;
            idx_q   <= dec_idx;
            wdata_q <= bus_wdata;
        end
    end

    // Output process: handshake, write strobes, read mux.
    always_comb begin
        bus_ready     = 1'b0;
        bus_ack       = 1'b0;
        bus_rdata     = '0;
        bus_bad       = 1'b0;
        sys_reset_req = 1'b0;
        wr_led        = 1'b0;
        wr_word       = 1'b0;
        wr_char       = 1'b0;
        wr_gp         = 1'b0;
        wr_i2c_out    = 1'b0;
        wr_i2c_oe     = 1'b0;
        wr_i2c_sel    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                bus_ready = 1'b1;
            end
            ST_WR: begin
                bus_ack = 1'b1;
                unique case (sel_q)
                    REG_LED:     wr_led     = 1'b1;
                    REG_WORD:    wr_word    = 1'b1;
                    REG_CHAR:    wr_char    = 1'b1;
                    REG_GPOUT:   wr_gp      = 1'b1;
                    REG_I2C_OUT: wr_i2c_out = 1'b1;
                    REG_I2C_OE:  wr_i2c_oe  = 1'b1;
                    REG_I2C_SEL: wr_i2c_sel = 1'b1;
                    REG_SWRST:   sys_reset_req = (wdata_q == DATA_W'(SWRST_KEY));
                    default: ;
                endcase
            end
            ST_RD: begin
                bus_ack = 1'b1;
                unique case (sel_q)
                    REG_LED:     bus_rdata = DATA_W'(led_q);
                    REG_GPOUT:   bus_rdata = DATA_W'(gp_q);
                    REG_I2C_IN:  bus_rdata = i2c_in_w;
                    REG_I2C_OUT: bus_rdata = i2c_out_w;
                    REG_I2C_OE:  bus_rdata = i2c_oe_w;
                    REG_I2C_SEL: bus_rdata = i2c_sel_w;
                    REG_NONE:    bus_bad   = 1'b1;
                    default:     bus_rdata = '0;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_q <= '0;
            gp_q  <= '0;
        end else begin
            if (wr_led) begin
                led_q <= wdata_q[LED_W-1:0];
            end
            if (wr_gp) begin
                gp_q <= wdata_q[GP_W-1:0];
            end
        end
    end

    board_ctl_display #(
        .NUM_CHARS (NUM_CHARS)
    ) u_display (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_we  (wr_word),
        .word_val (wdata_q[4*NUM_CHARS-1:0]),
        .char_we  (wr_char),
        .char_idx (idx_q),
        .char_val (wdata_q[7:0]),
        .chars    (disp_chars)
    );

    board_ctl_i2c #(
        .DATA_W (DATA_W)
    ) u_i2c (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_we   (wr_i2c_out),
        .oe_we    (wr_i2c_oe),
        .sel_we   (wr_i2c_sel),
        .wdata    (wdata_q),
        .sda_in   (i2c_sda_i),
        .scl_o    (i2c_scl_o),
        .sda_o    (i2c_sda_o),
        .oe       (i2c_oe),
        .sel      (i2c_sel),
        .in_word  (i2c_in_w),
        .out_word (i2c_out_w),
        .oe_word  (i2c_oe_w),
        .sel_word (i2c_sel_w)
    );

    assign led_bar = led_q;
    assign gp_out  = gp_q;

endmodule

// File: rtl/board_ctl_checker.sv
module board_ctl_checker #(
    parameter int DATA_W = 32,
    parameter int LED_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_ready,
    input logic              bus_ack,
    input logic              bus_bad,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [LED_W-1:0]  led_bar,
    input logic              sys_reset_req
);

    a_r12_ack_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready) |=> bus_ack);

    a_r12_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    a_r12_busy_during_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> !bus_ready);

    a_r11_bad_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_bad |-> (bus_ack && bus_rdata == '0));

    a_r10_reset_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);

    a_r10_reset_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> (bus_ack && !bus_bad));

    a_r2_led_holds_without_access: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack |=> $stable(led_bar));

endmodule

bind board_ctl board_ctl_checker #(
    .DATA_W (DATA_W),
    .LED_W  (LED_W)
) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_req       (bus_req),
    .bus_ready     (bus_ready),
    .bus_ack       (bus_ack),
    .bus_bad       (bus_bad),
    .bus_rdata     (bus_rdata),
    .led_bar       (led_bar),
    .sys_reset_req (sys_reset_req)
);

// File: tb/board_ctl_test.sv
`timescale 1ns/1ps
module board_ctl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_ack, bus_bad;
    logic [31:0] bus_rdata;
    logic [7:0]  led_bar, gp_out;
    logic [63:0] disp_chars;
    logic        sys_reset_req, i2c_scl_o, i2c_sda_o, i2c_sel;
    logic [1:0]  i2c_oe;
    logic        i2c_sda_i = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    typedef struct {
        logic [31:0] rdata;
        logic        bad;
        logic        rst;
        string       tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #4 clk = ~clk;

    board_ctl uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_req       (bus_req),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_ready     (bus_ready),
        .bus_ack       (bus_ack),
        .bus_rdata     (bus_rdata),
        .bus_bad       (bus_bad),
        .led_bar       (led_bar),
        .disp_chars    (disp_chars),
        .gp_out        (gp_out),
        .sys_reset_req (sys_reset_req),
        .i2c_scl_o     (i2c_scl_o),
        .i2c_sda_o     (i2c_sda_o),
        .i2c_oe        (i2c_oe),
        .i2c_sel       (i2c_sel),
        .i2c_sda_i     (i2c_sda_i)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Monitor: pops the expected item on each acknowledge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_ack) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R12 unexpected ack", 64'(bus_ack), 64'd0);
                end else begin
                    exp_item_t e;
                    e = exp_q.pop_front();
                    check(bus_rdata == e.rdata, {e.tag, " rdata"}, 64'(bus_rdata), 64'(e.rdata));
                    check(bus_bad == e.bad, {e.tag, " bad"}, 64'(bus_bad), 64'(e.bad));
                    check(sys_reset_req == e.rst, {e.tag, " reset_req"},
                          64'(sys_reset_req), 64'(e.rst));
                    check(!bus_ready, "R12 ready during ack", 64'(bus_ready), 64'd0);
                end
            end else begin
                check(!sys_reset_req, "R10 stray reset_req", 64'(sys_reset_req), 64'd0);
            end
        end
    end

    // Driver: one access, pushing its expected result.
    task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] data,
                          input logic [31:0] exp_rd, input bit exp_bad, input bit exp_rst,
                          input string tag);
        exp_item_t e;
        e.rdata = exp_rd;
        e.bad   = exp_bad;
        e.rst   = exp_rst;
        e.tag   = tag;
        exp_q.push_back(e);
        @(negedge clk);
        bus_req   = 1'b1;
        bus_we    = we;
        bus_addr  = addr;
        bus_wdata = data;
        @(negedge clk);
        bus_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] addr, input logic [31:0] data, input string tag);
        access(1'b1, addr, data, 32'h0, 1'b0, 1'b0, tag);
    endtask

    task automatic rd(input logic [31:0] addr, input logic [31:0] exp, input string tag);
        access(1'b0, addr, 32'h0, exp, 1'b0, 1'b0, tag);
    endtask

    function automatic logic [63:0] hex_chars(input logic [31:0] w);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) begin
            logic [3:0] n;
            n = w[31 - 4*i -: 4];
            r[8*i +: 8] = (n < 10) ? (8'h30 + 8'(n)) : (8'h37 + 8'(n));
        end
        return r;
    endfunction

    initial begin
        logic [63:0] snap;
        logic [63:0] expc;
        #20;
        @(negedge clk);
        // R5 reset state
        check(disp_chars == {8{8'h20}}, "R5 chars", disp_chars, {8{8'h20}});
        check(led_bar == 8'h0 && gp_out == 8'h0, "R5 led/gp", {led_bar, gp_out}, 64'h0);
        check({i2c_scl_o, i2c_sda_o, i2c_oe, i2c_sel} == 5'b0, "R5 i2c",
              64'({i2c_scl_o, i2c_sda_o, i2c_oe, i2c_sel}), 64'h0);
        check(bus_ready && !bus_ack && !sys_reset_req, "R5 handshake",
              64'({bus_ready, bus_ack, sys_reset_req}), 64'b100);
        rst_n = 1'b1;

        rd(32'h0000_0000, 32'h0, "R6 switch");

        wr(32'h0000_0408, 32'h1234_56A5, "R2 led write");
        check(led_bar == 8'hA5, "R2 led port", 64'(led_bar), 64'hA5);
        rd(32'h0000_0408, 32'h0000_00A5, "R2 led read");

        wr(32'hABC0_0408, 32'h0000_003C, "R1 alias write");
        check(led_bar == 8'h3C, "R1 alias led", 64'(led_bar), 64'h3C);
        rd(32'h7FF0_0408, 32'h0000_003C, "R1 alias read");

        wr(32'h0000_0410, 32'h0123_ABEF, "R3 word write");
        check(disp_chars == hex_chars(32'h0123_ABEF), "R3 hex a", disp_chars,
              hex_chars(32'h0123_ABEF));
        check(disp_chars[7:0] == 8'h30 && disp_chars[63:56] == 8'h46, "R3 order",
              disp_chars, 64'h46_00_00_00_00_00_00_30);
        wr(32'h0000_0410, 32'hFEDC_9875, "R3 word write b");
        check(disp_chars == hex_chars(32'hFEDC_9875), "R3 hex b", disp_chars,
              hex_chars(32'hFEDC_9875));

        expc = hex_chars(32'hFEDC_9875);
        wr(32'h0000_0430, 32'h0000_0141, "R4 char3");
        expc[31:24] = 8'h41;
        check(disp_chars == expc, "R4 char3", disp_chars, expc);
        wr(32'h0000_0450, 32'h0000_007A, "R4 char7");
        expc[63:56] = 8'h7A;
        check(disp_chars == expc, "R4 char7", disp_chars, expc);
        wr(32'h0000_0418, 32'h0000_0021, "R4 char0");
        expc[7:0] = 8'h21;
        check(disp_chars == expc, "R4 char0", disp_chars, expc);

        // R11 unaligned slot offset: ignored on write, bad on read
        snap = disp_chars;
        wr(32'h0000_041C, 32'h0000_0055, "R11 unaligned write");
        check(disp_chars == snap, "R11 chars kept", disp_chars, snap);
        access(1'b0, 32'h0000_041C, 32'h0, 32'h0, 1'b1, 1'b0, "R11 unaligned read");
        access(1'b0, 32'h0000_0004, 32'h0, 32'h0, 1'b1, 1'b0, "R11 bad read");
        wr(32'h0000_0C00, 32'hFFFF_FFFF, "R11 undecoded write");
        check(led_bar == 8'h3C && gp_out == 8'h0 && disp_chars == snap, "R11 no effect",
              {led_bar, gp_out, 48'h0}, {8'h3C, 8'h0, 48'h0});
        rd(32'h0000_0410, 32'h0, "R11 write-only read");

        access(1'b1, 32'h0000_0500, 32'h0000_0042, 32'h0, 1'b0, 1'b1, "R10 key");
        access(1'b1, 32'h0000_0500, 32'h0000_0043, 32'h0, 1'b0, 1'b0, "R10 wrong key");
        access(1'b1, 32'h0000_0500, 32'h0100_0042, 32'h0, 1'b0, 1'b0, "R10 upper bits");

        wr(32'h0000_0A00, 32'hFFFF_FF5A, "R9 gp write");
        check(gp_out == 8'h5A, "R9 gp port", 64'(gp_out), 64'h5A);
        rd(32'h0000_0A00, 32'h0000_005A, "R9 gp read");

        wr(32'h0000_0B10, 32'h0000_0003, "R7 out write");
        check(i2c_scl_o && i2c_sda_o, "R7 scl/sda 11", 64'({i2c_scl_o, i2c_sda_o}), 64'b11);
        wr(32'h0000_0B10, 32'hFFFF_FFFE, "R7 out write b");
        check(i2c_scl_o && !i2c_sda_o, "R7 scl/sda 10", 64'({i2c_scl_o, i2c_sda_o}), 64'b10);
        rd(32'h0000_0B10, 32'h0000_0002, "R7 out read");
        wr(32'h0000_0B08, 32'h0000_00FF, "R7 oe write");
        check(i2c_oe == 2'b11, "R7 oe port", 64'(i2c_oe), 64'b11);
        rd(32'h0000_0B08, 32'h0000_0003, "R7 oe read");
        wr(32'h0000_0B18, 32'h0000_00FE, "R7 sel write 0");
        check(!i2c_sel, "R7 sel 0", 64'(i2c_sel), 64'h0);
        wr(32'h0000_0B18, 32'h0000_0003, "R7 sel write 1");
        check(i2c_sel, "R7 sel 1", 64'(i2c_sel), 64'h1);
        rd(32'h0000_0B18, 32'h0000_0001, "R7 sel read");

        i2c_sda_i = 1'b1;
        rd(32'h0000_0B00, 32'h0000_0003, "R8 in sda1");
        i2c_sda_i = 1'b0;
        rd(32'h0000_0B00, 32'h0000_0002, "R8 in sda0");
        wr(32'h0000_0B10, 32'h0000_0001, "R8 scl low");
        i2c_sda_i = 1'b1;
        rd(32'h0000_0B00, 32'h0000_0001, "R8 in scl0");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R12 all acked", 64'(exp_q.size()), 64'd0);
        finish_run();
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            check(1'b0, "watchdog", 64'(cycles), 64'd0);
            finish_run();
        end
    end

endmodule